// File: doc/BRIEF.md
# Paged ROM Sample Playback Sequencer

This block streams 8-bit audio bytes out of one of several external sample ROMs into a DAC holding register. A host writes a control byte that names a ROM and a starting page. It then issues commands to load that position and to start playback. An internal divider turns the system clock into a free-running sample strobe. While playback is enabled, each strobe reads one byte at the current address, moves it to the DAC register and steps the address.

The address is split into two parts. The upper part is a page number preset by the host. The lower part is the offset within the page, which counts up and carries into the page field. A sample therefore always starts on a page boundary but may run across several pages.

A reserved byte value ends the sample. When that byte is read, the block stops playback by itself, keeps the byte away from the DAC, and pulls an active-low interrupt line to the host. The line stays low until the host sends a stop or a load command.

Top module: `sample_rom_player`

## Requirements
- R1: The control byte carries the ROM number in bits 7:4 and the page in bits 3:0. A command value of 0x40 (load) sets `rom_addr_o` to {page, 14 zero bits} and latches the ROM number. A control write alone does not change `rom_addr_o` or `rom_cs_o`.
- R2: `rom_cs_o` has bit n high for latched ROM number n when n < NUM_ROMS (10), and it is all zero for larger numbers. At most one bit is ever high.
- R3: The sample strobe repeats every `tick_div_i`+1 clock cycles whether or not playback is on. While playing, the address changes at most once per strobe.
- R4: On each strobe during playback where `rom_data_i` is not 0xFF, `dac_o` takes `rom_data_i` and `rom_addr_o` increments by one in the next cycle.
- R5: An offset step past 0x3FFF carries into the page field, so playback continues at offset 0 of the next page.
- R6: On a strobe during playback where `rom_data_i` is 0xFF, `dac_o` keeps its value, `rom_addr_o` holds, playback stops and `irq_no` goes low in the next cycle. `dac_o` never shows 0xFF.
- R7: Once low, `irq_no` stays low until a command of 0x00 (stop) or 0x40 (load) is written, which returns it high.
- R8: Command 0x80 starts playback and command 0x00 stops it. While stopped, `rom_addr_o` does not change, and a later start resumes from the held address.
- R9: Command values other than 0x00, 0x40 and 0x80 have no effect.
- R10: After reset, `rom_addr_o` is 0, ROM 0 is selected, `dac_o` is 0, `irq_no` is high and playback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for the control byte |
| ctrl_i | input | 8 | Control byte: ROM number in bits 7:4, page in bits 3:0 |
| cmd_we_i | input | 1 | Write strobe for the command byte |
| cmd_i | input | 8 | Command byte: 0x40 load, 0x80 start, 0x00 stop |
| tick_div_i | input | 16 | Strobe period minus one, in clock cycles |
| rom_data_i | input | 8 | Byte returned by the selected ROM at `rom_addr_o` |
| rom_addr_o | output | 18 | Sample address: page in bits 17:14, offset in bits 13:0 |
| rom_cs_o | output | 10 | One select line per ROM, active high |
| dac_o | output | 8 | DAC holding register |
| irq_no | output | 1 | End-of-sample interrupt, active low |

## Verification
The hardest case to reach from the ports is the page carry: an offset crossing 0x3FFF needs more than sixteen thousand strobes without a stray end byte. The bench reaches it with the fastest strobe setting and a ROM model that places the end marker just past the page boundary. Random plays use random ROMs, pages, lengths and strobe rates, and each checks the final address and DAC byte. Directed runs cover a stop in the middle of a sample followed by a resume, ignored command codes, an end marker in the first byte, and out-of-range ROM numbers.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] END_MARK = 8'hFF;

  typedef enum logic [7:0] {
    CMD_STOP  = 8'h00,
    CMD_LOAD  = 8'h40,
    CMD_START = 8'h80
  } cmd_e;
endpackage

// File: rtl/srp_tick_gen.sv
module srp_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= div_i;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/srp_addr_ctr.sv
module srp_addr_ctr #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned OFFS_W = 14,
  localparam int unsigned ADDR_W = PAGE_W + OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  assign addr_o = addr_q;

  // full-width increment: offset carries straight into the page field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= {page_i, {OFFS_W{1'b0}}};
    else if (adv_i)  addr_q <= addr_q + 1'b1;
  end
endmodule

// File: rtl/srp_cs_decode.sv
module srp_cs_decode #(
  parameter int unsigned CHIP_W   = 4,
  parameter int unsigned NUM_ROMS = 10
) (
  input  logic [CHIP_W-1:0]   chip_i,
  output logic [NUM_ROMS-1:0] cs_o
);
  for (genvar i = 0; i < NUM_ROMS; i++) begin : g_cs
    assign cs_o[i] = (chip_i == CHIP_W'(i));
  end
endmodule

// File: rtl/sample_rom_player.sv
module sample_rom_player
  import srp_pkg::*;
#(
  parameter int unsigned CHIP_W   = 4,
  parameter int unsigned PAGE_W   = 4,
  parameter int unsigned OFFS_W   = 14,
  parameter int unsigned NUM_ROMS = 10,
  parameter int unsigned DIV_W    = 16,
  localparam int unsigned ADDR_W  = PAGE_W + OFFS_W,
  localparam int unsigned CTRL_W  = CHIP_W + PAGE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic                cmd_we_i,
  input  logic [7:0]          cmd_i,
  input  logic [DIV_W-1:0]    tick_div_i,
  input  logic [DATA_W-1:0]   rom_data_i,
  output logic [ADDR_W-1:0]   rom_addr_o,
  output logic [NUM_ROMS-1:0] rom_cs_o,
  output logic [DATA_W-1:0]   dac_o,
  output logic                irq_no
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CHIP_W-1:0] chip_q;
  logic              play_q, irq_q;
  logic [DATA_W-1:0] dac_q;
  logic              tick, fetch, is_end;
  logic              cmd_load, cmd_start, cmd_stop;

  assign cmd_load  = cmd_we_i && (cmd_i == CMD_LOAD);
  assign cmd_start = cmd_we_i && (cmd_i == CMD_START);
  assign cmd_stop  = cmd_we_i && (cmd_i == CMD_STOP);

  srp_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (tick_div_i),
    .tick_o(tick)
  );

  assign fetch  = play_q && tick;
  assign is_end = (rom_data_i == END_MARK);

  srp_addr_ctr #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cmd_load),
    .page_i(ctrl_q[PAGE_W-1:0]),
    .adv_i (fetch && !is_end),
    .addr_o(rom_addr_o)
  );

  srp_cs_decode #(.CHIP_W(CHIP_W), .NUM_ROMS(NUM_ROMS)) u_cs (
    .chip_i(chip_q),
    .cs_o  (rom_cs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      chip_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_i;
      if (cmd_load)  chip_q <= ctrl_q[CTRL_W-1:PAGE_W];
    end
  end

  // host commands win over the end marker in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_q <= 1'b0;
      irq_q  <= 1'b0;
      dac_q  <= '0;
    end else begin
      if (fetch && !is_end) dac_q <= rom_data_i;
      if (cmd_load || cmd_stop) begin
        play_q <= 1'b0;
        irq_q  <= 1'b0;
      end else if (cmd_start) begin
        play_q <= 1'b1;
      end else if (fetch && is_end) begin
        play_q <= 1'b0;
        irq_q  <= 1'b1;
      end
    end
  end

  assign dac_o  = dac_q;
  assign irq_no = !irq_q;
endmodule

// File: rtl/sample_rom_player_chk.sv
module sample_rom_player_chk #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned NUM_ROMS = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_we_i,
  input logic [7:0]          cmd_i,
  input logic [7:0]          rom_data_i,
  input logic [ADDR_W-1:0]   rom_addr_o,
  input logic [NUM_ROMS-1:0] rom_cs_o,
  input logic [7:0]          dac_o,
  input logic                irq_no,
  input logic                play_q,
  input logic                tick
);
  logic host_clr, host_cmd;
  assign host_clr = cmd_we_i && (cmd_i == 8'h00 || cmd_i == 8'h40);
  assign host_cmd = cmd_we_i && (cmd_i == 8'h00 || cmd_i == 8'h40 || cmd_i == 8'h80);

  p_cs_onehot0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rom_cs_o));

  p_dac_no_mark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_o != 8'hFF);

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_q && tick && rom_data_i != 8'hFF && !host_cmd)
      |=> (rom_addr_o == $past(rom_addr_o) + 1'b1) && (dac_o == $past(rom_data_i)));

  p_mark_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_q && tick && rom_data_i == 8'hFF && !host_cmd)
      |=> !irq_no && !play_q && $stable(rom_addr_o) && $stable(dac_o));

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !host_clr) |=> !irq_no);

  p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_clr |=> irq_no);

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!play_q && !(cmd_we_i && cmd_i == 8'h40)) |=> $stable(rom_addr_o));

  p_step_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !(cmd_we_i && cmd_i == 8'h40)) |=> $stable(rom_addr_o));
endmodule

bind sample_rom_player sample_rom_player_chk #(
  .ADDR_W(ADDR_W), .NUM_ROMS(NUM_ROMS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_we_i  (cmd_we_i),
  .cmd_i     (cmd_i),
  .rom_data_i(rom_data_i),
  .rom_addr_o(rom_addr_o),
  .rom_cs_o  (rom_cs_o),
  .dac_o     (dac_o),
  .irq_no    (irq_no),
  .play_q    (play_q),
  .tick      (tick)
);

// File: tb/sample_rom_player_tb.sv
module sample_rom_player_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, cmd_we = 1'b0;
  logic [7:0]  ctrl = '0, cmd = '0;
  logic [15:0] tick_div = '0;
  logic [7:0]  rom_data;
  logic [17:0] rom_addr;
  logic [9:0]  rom_cs;
  logic [7:0]  dac;
  logic        irq_n;

  int unsigned n_run = 0, n_fail = 0, cyc = 0;
  logic [3:0]  cur_chip = '0;
  logic [17:0] mark_addr = 18'h3FFFF;
  logic [7:0]  last_dac = '0;

  always #4 clk = ~clk;

  sample_rom_player u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_i(ctrl),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .tick_div_i(tick_div),
    .rom_data_i(rom_data), .rom_addr_o(rom_addr), .rom_cs_o(rom_cs),
    .dac_o(dac), .irq_no(irq_n)
  );

  function automatic logic [7:0] rom_byte(logic [17:0] a, logic [3:0] c);
    logic [17:0] h;
    h = a ^ (a >> 7) ^ (18'(c) * 18'd29);
    return {1'b0, h[6:0]};
  endfunction

  assign rom_data = (rom_addr == mark_addr) ? 8'hFF : rom_byte(rom_addr, cur_chip);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl = v; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic write_cmd(input logic [7:0] v);
    @(negedge clk); cmd = v; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (!irq_n) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [9:0] exp_cs(logic [3:0] c);
    return (c < 4'd10) ? (10'b1 << c) : 10'b0;
  endfunction

  // load, play to the marker, check end state, then stop
  task automatic play(input logic [3:0] chip, input logic [3:0] page, input int len);
    bit seen;
    logic [17:0] base;
    base = {page, 14'b0};
    write_ctrl({chip, page});
    mark_addr = base + 18'(len);
    write_cmd(8'h40);
    cur_chip = chip;
    check(rom_addr == base, "R1 load addr", rom_addr, base);
    check(rom_cs == exp_cs(chip), "R2 cs", rom_cs, exp_cs(chip));
    write_cmd(8'h80);
    wait_irq(seen);
    check(seen, "R6 irq", irq_n, 0);
    if (len > 0) last_dac = rom_byte(mark_addr - 18'd1, chip);
    check(rom_addr == mark_addr, "R4 end addr", rom_addr, mark_addr);
    check(dac == last_dac, "R6 dac holds last byte", dac, last_dac);
    repeat (5) @(negedge clk);
    check(!irq_n && rom_addr == mark_addr, "R7 irq held, addr frozen", {irq_n, rom_addr}, mark_addr);
    write_cmd(8'h00);
    check(irq_n, "R7 stop clears irq", irq_n, 1);
  endtask

  initial begin
    int gap;
    logic [17:0] held;
    bit seen;
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    check(rom_addr == 0 && irq_n && dac == 0, "R10 reset addr/irq/dac", {rom_addr, irq_n, dac}, 18'h0 << 9 | 9'h100);
    check(rom_cs == 10'b1, "R10 reset cs", rom_cs, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // control write without load leaves outputs alone
    write_ctrl(8'h2B);
    repeat (3) @(negedge clk);
    check(rom_addr == 0 && rom_cs == 10'b1, "R1 ctrl alone no effect", rom_addr, 0);

    // strobe period and one step per strobe
    tick_div = 16'd3;
    write_ctrl(8'h11);
    mark_addr = {4'd1, 14'd0} + 18'd100;
    write_cmd(8'h40); cur_chip = 4'd1;
    write_cmd(8'h80);
    held = rom_addr;
    while (rom_addr == held) @(negedge clk);
    held = rom_addr; gap = 0;
    while (rom_addr == held) begin @(negedge clk); gap++; end
    check(gap == 4, "R3 strobe period", gap, 4);
    check(rom_addr == held + 1, "R4 single step", rom_addr, held + 1);

    // ignored code while playing keeps playing
    write_cmd(8'h13);
    held = rom_addr;
    repeat (12) @(negedge clk);
    check(rom_addr != held, "R9 bad code does not stop", rom_addr, held);

    // stop mid-sample, stay frozen, then resume
    write_cmd(8'h00);
    held = rom_addr;
    repeat (30) @(negedge clk);
    check(rom_addr == held && irq_n, "R8 stop freezes", rom_addr, held);
    write_cmd(8'h55);
    write_cmd(8'hC0);
    repeat (20) @(negedge clk);
    check(rom_addr == held, "R9 bad codes ignored while stopped", rom_addr, held);
    write_cmd(8'h80);
    wait_irq(seen);
    last_dac = rom_byte(mark_addr - 18'd1, 4'd1);
    check(seen && rom_addr == mark_addr, "R8 resume reaches end", rom_addr, mark_addr);
    check(dac == last_dac, "R4 dac last byte", dac, last_dac);
    write_cmd(8'h40);
    check(irq_n, "R7 load clears irq", irq_n, 1);

    // end marker as first byte
    tick_div = 16'd1;
    play(4'd9, 4'd15, 0);

    // page carry across offset 0x3FFF
    tick_div = 16'd0;
    play(4'd2, 4'd3, 16384 + 3);
    check(rom_addr[17:14] == 4'd4, "R5 page carry", rom_addr[17:14], 4);

    // out of range ROM numbers
    for (int c = 10; c < 16; c++) begin
      write_ctrl({4'(c), 4'd0});
      write_cmd(8'h40);
      check(rom_cs == 10'b0, "R2 out of range cs", rom_cs, 0);
    end

    // random plays
    for (int k = 0; k < 25; k++) begin
      tick_div = 16'($urandom_range(0, 3));
      play(4'($urandom_range(0, 9)), 4'($urandom_range(0, 15)), int'($urandom_range(1, 60)));
    end

    finish_run();
  end
endmodule